// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block reads a square grid of push keys wired as rows and columns. Each column line has a pull-up resistor. On each tick of a slow scan enable, nominally 200 Hz from the chip's clock divider, the block selects one row by driving it low. It reads the columns to find out whether a key on that row is closed. Only the selected row is driven. Every other row has its output enable removed, so two closed keys sharing a column can never connect a low-driven row to a high-driven one.

When a column reads low, the scanner stays on the current row. It stores a 4-bit hexadecimal key number, suitable for a seven-segment decoder, and raises a one-clock valid strobe. It stays on that row until every column reads high again, and then it moves on to the next row. Column inputs pass through a synchronizer before the state machine uses them. The asynchronous active-low clear is released in step with the clock.

Top module: `keypad_scanner`

## Requirements
- R1: While in reset and after it is released, the block selects row 0 (`row_oe` = 4'b0001), holds `key_valid` at 0 and holds `key_code` at 0.
- R2: Exactly one bit of `row_oe` is 1 at all times, and `row_out` is always all zeros, so a row is either driven low or released.
- R3: With no key closed, every cycle in which `scan_en` is 1 moves the selected row to the next index, in the order 0, 1, 2, 3, 0.
- R4: In a cycle where `scan_en` is 0, the selected row, the state and `key_code` do not change.
- R5: When a closed key is seen on row r and column c (both numbered from 0), `key_code` becomes r*4+c and keeps that value until the next detection.
- R6: `key_valid` is high for exactly one clock for each detected press, in the cycle after the `scan_en` cycle that saw it.
- R7: After a detection, the row stays selected and no further strobe is produced until a `scan_en` cycle sees all columns high. Scanning then resumes at the following row.
- R8: If several columns read low at the same time, the lowest column index is reported.
- R9: Columns are acted on only in `scan_en` cycles, using values that passed through a two-flop synchronizer. A key closed and opened again while `scan_en` stays low produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| scan_en | input | 1 | One-clock scan tick from the divider |
| row_out | output | 4 | Row drive values (always low) |
| row_oe | output | 4 | Row output enables; 1 drives the row, 0 releases it |
| col_in | input | 4 | Column lines with pull-ups; 0 means a closed key on the driven row |
| key_code | output | 4 | Latched key number, row*4+column |
| key_valid | output | 1 | One-clock strobe for a new key |

## Verification
The bench models the keypad: a column reads low only when a closed key sits on a row that is both enabled and driven low. Each of the 16 keys is closed alone. This shows whether every row/column pair is turned into the right number, and whether a held key gives exactly one strobe. Two keys are then closed on one row, which checks the lowest-column rule. Two keys are closed in one column, which shows that the first row reached wins and that the other row stays released. Closing a key while the scan tick is held off shows that nothing moves or fires without `scan_en`.

// File: rtl/kps_pkg.sv
package kps_pkg;
  typedef enum logic [0:0] {
    KPS_SCAN = 1'b0,
    KPS_HOLD = 1'b1
  } kps_state_e;
endpackage

// File: rtl/kps_rst_sync.sv
module kps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/kps_col_sync.sv
module kps_col_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/kps_prio_enc.sv
module kps_prio_enc #(
  parameter int WIDTH = 4,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req_n,
  output logic             any,
  output logic [IDXW-1:0]  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = WIDTH-1; i >= 0; i--) begin
      if (!req_n[i]) begin
        any = 1'b1;
        idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/kps_fsm.sv
module kps_fsm
  import kps_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CODE_W = (ROWS*COLS > 1) ? $clog2(ROWS*COLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              hit,
  input  logic [COL_W-1:0]  hit_col,
  output logic [ROW_W-1:0]  row_idx,
  output logic [CODE_W-1:0] code,
  output logic              valid
);
  kps_state_e        state_q, state_d;
  logic [ROW_W-1:0]  row_q, row_d, row_next;
  logic [CODE_W-1:0] code_q, code_d;
  logic              valid_q, valid_d;

  assign row_next = (row_q == ROW_W'(ROWS-1)) ? '0 : row_q + 1'b1;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    code_d  = code_q;
    valid_d = 1'b0;
    if (scan_en) begin
      case (state_q)
        KPS_SCAN: begin
          if (hit) begin
            code_d  = CODE_W'(row_q) * CODE_W'(COLS) + CODE_W'(hit_col);
            valid_d = 1'b1;
            state_d = KPS_HOLD;
          end else begin
            row_d = row_next;
          end
        end
        KPS_HOLD: begin
          if (!hit) begin
            state_d = KPS_SCAN;
            row_d   = row_next;
          end
        end
        default: state_d = KPS_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KPS_SCAN;
      row_q   <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      code_q  <= code_d;
      valid_q <= valid_d;
    end
  end

  assign row_idx = row_q;
  assign code    = code_q;
  assign valid   = valid_q;

  // R4: no tick, no movement
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ($stable(row_q) && $stable(state_q) && $stable(code_q)));
  // R6: the strobe never lasts two clocks
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7: a held key keeps its row and gives no new strobe
  p_hold_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KPS_HOLD && hit) |=> ($stable(row_q) && !valid_q));
  // R6: a strobe is only issued on entry to the hold state
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (state_q == KPS_HOLD && $past(state_q) == KPS_SCAN));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS        = 4,
  parameter int COLS        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CODE_W = (ROWS*COLS > 1) ? $clog2(ROWS*COLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  output logic [ROWS-1:0]   row_out,
  output logic [ROWS-1:0]   row_oe,
  input  logic [COLS-1:0]   col_in,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid
);
  logic             rst_sync_n;
  logic [COLS-1:0]  col_s;
  logic             hit;
  logic [COL_W-1:0] hit_col;
  logic [ROW_W-1:0] row_idx;

  kps_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  kps_col_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) u_csync (
    .clk(clk), .rst_n(rst_sync_n), .d(col_in), .q(col_s));

  kps_prio_enc #(.WIDTH(COLS)) u_enc (
    .req_n(col_s), .any(hit), .idx(hit_col));

  kps_fsm #(.ROWS(ROWS), .COLS(COLS)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .scan_en(scan_en),
    .hit(hit), .hit_col(hit_col),
    .row_idx(row_idx), .code(key_code), .valid(key_valid));

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_oe[r]  = (row_idx == ROW_W'(r));
      assign row_out[r] = 1'b0;
    end
  endgenerate

  // R2: exactly one row enabled, never driven high
  p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(row_oe) == 1) && (row_out == '0));
  // R5: the strobed code names the row that is being held
  p_code_row_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    key_valid |-> row_oe[key_code / CODE_W'(COLS)]);
  // R9: a strobe requires a tick in the cycle before
  p_tick_before_valid_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(key_valid) |-> $past(scan_en));
endmodule

// File: tb/keypad_scanner_tb.sv
`timescale 1ns/1ps
module keypad_scanner_tb;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scan_en;
  logic [3:0] row_out, row_oe, col_in, key_code;
  logic       key_valid;
  logic [15:0] pressed;
  logic       tick_on;

  int vectors = 0, miscompares = 0;
  int tick_cnt = 0;
  int vcnt = 0;
  int last_code = -1;
  bit done = 0;

  // reference model state
  int   m_row, m_code;
  bit   m_hold, m_valid;
  logic [3:0] m_s1, m_s2;

  always #2 clk = ~clk;

  keypad_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
    .row_out(row_out), .row_oe(row_oe), .col_in(col_in),
    .key_code(key_code), .key_valid(key_valid));

  // pull-up keypad matrix: a column is low only through a driven-low row
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      col_in[c] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (pressed[r*4+c] && row_oe[r] && !row_out[r]) col_in[c] = 1'b0;
    end
  end

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_row = 0; m_code = 0; m_hold = 0; m_valid = 0;
      m_s1 = 4'hF; m_s2 = 4'hF;
    end else begin
      logic [3:0] seen;
      seen = m_s2;
      m_s2 = m_s1;
      m_s1 = col_in;
      m_valid = 0;
      if (scan_en) begin
        if (!m_hold) begin
          if (seen != 4'hF) begin
            int lc;
            lc = -1;
            for (int c = 3; c >= 0; c--) if (!seen[c]) lc = c;
            m_code = m_row*4 + lc;
            m_valid = 1; m_hold = 1;
          end else m_row = (m_row + 1) % 4;
        end else if (seen == 4'hF) begin
          m_hold = 0; m_row = (m_row + 1) % 4;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock compare, tick generation, strobe counting
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(row_out == 4'b0 && $countones(row_oe) == 1, "R2", "row drive",
            int'(row_oe), 1 << m_row);
      check(row_oe == 4'(1 << m_row), "R3", "row_oe", int'(row_oe), 1 << m_row);
      check(int'(key_code) == m_code, "R5", "key_code", int'(key_code), m_code);
      check(key_valid == m_valid, "R6", "key_valid", int'(key_valid), int'(m_valid));
      if (key_valid) begin vcnt++; last_code = int'(key_code); end
    end
    if (tick_on) begin
      tick_cnt = (tick_cnt + 1) % DIV;
      scan_en <= (tick_cnt == 0);
    end else scan_en <= 1'b0;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_one(input int k);
    vcnt = 0; last_code = -1;
    pressed = 16'(1 << k);
    wait_clk(DIV*12);
    pressed = '0;
    wait_clk(DIV*6);
    check(vcnt == 1, "R7", "strobes per held key", vcnt, 1);
    check(last_code == k, "R5", "code of key", last_code, k);
  endtask

  initial begin
    rst_n = 1'b0; scan_en = 1'b0; tick_on = 1'b0; pressed = '0;
    wait_clk(3);
    // R1: reset state
    check(row_oe == 4'b0001, "R1", "row_oe in reset", int'(row_oe), 1);
    check(key_valid == 1'b0 && key_code == 4'd0, "R1", "outputs in reset",
          int'(key_code), 0);
    rst_n = 1'b1;
    wait_clk(5);
    check(row_oe == 4'b0001, "R1", "row_oe after release", int'(row_oe), 1);
    tick_on = 1'b1;
    // R3: idle rotation (compared every clock by the model)
    wait_clk(DIV*9);
    // R5, R6, R7: every key alone
    for (int k = 0; k < 16; k++) press_one(k);
    // R8: two keys on row 2, columns 1 and 3
    vcnt = 0; pressed = 16'h0A00;
    wait_clk(DIV*12); pressed = '0; wait_clk(DIV*6);
    check(vcnt == 1, "R8", "strobes two keys one row", vcnt, 1);
    check(last_code == 9, "R8", "lowest column", last_code, 9);
    // two keys in one column (rows 1 and 3, column 2)
    vcnt = 0; pressed = 16'h4040;
    wait_clk(DIV*12); pressed = '0; wait_clk(DIV*6);
    check(vcnt == 1, "R7", "strobes two keys one column", vcnt, 1);
    check(last_code == 6 || last_code == 14, "R5", "same column code",
          last_code, 6);
    // R4, R9: tick held off; key closed and opened has no effect
    tick_on = 1'b0;
    wait_clk(2);
    begin
      logic [3:0] oe_before;
      oe_before = row_oe;
      vcnt = 0;
      pressed = 16'hFFFF;
      wait_clk(40);
      pressed = '0;
      wait_clk(5);
      check(row_oe == oe_before, "R4", "row without tick", int'(row_oe),
            int'(oe_before));
      check(vcnt == 0, "R9", "strobe without tick", vcnt, 0);
    end
    tick_on = 1'b1;
    wait_clk(DIV*6);
    check(vcnt == 0, "R9", "strobe after ignored press", vcnt, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule